// File: doc/BRIEF.md
# HSYNC Grid Aligner

This block takes a horizontal sync signal that arrives with cycle-to-cycle jitter and re-times its transitions onto a grid of fixed pixel groups, so that downstream panel logic sees clean, repeatable line timing. The grid is tied to the pixel stream. A modulo-`GRID` phase counter restarts at every rising edge of the data-enable input. A new HSYNC level is accepted only in the cycle where the phase is zero. In between, any change on the raw input stays pending. A change that goes back before the next grid point is lost, and so is filtered out as jitter.

An active-low control input selects the mode. When it is low the grid alignment is used, and HSYNC trails the pixel data by an extra 0 to `GRID-1` clocks. When it is high the block is a plain delay line whose latency equals the data-path latency `PIPE_LAT`. The bypass is the safe setting for timings whose sync width and porches are not whole multiples of the grid. The alignment only behaves correctly when those intervals are multiples of `GRID` pixel clocks. Both paths run all the time, and the mode input only selects which one drives the output.

Top module: `hsync_aligner`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hs_out` is 0.
- R2: With `dejit_n` high, `hs_out` follows `hs_in` through exactly `PIPE_LAT` registers. A value sampled at clock edge N is visible after edge N+PIPE_LAT-1.
- R3: The clock edge at which `de_in` is sampled high, after having been sampled low at the previous edge, is grid phase 0. The following edges count phases 1, 2, … and wrap from GRID-1 back to 0.
- R4: With `dejit_n` low, `hs_in` may change at phase k and then hold until the next phase-0 edge. That edge is edge N+(GRID-k)%GRID, where N is the edge at which the change is first sampled. The new level is visible on `hs_out` after that edge plus PIPE_LAT-1 further edges. This applies to rising and to falling changes.
- R5: With `dejit_n` low, a pulse on `hs_in` that begins and ends strictly between two phase-0 edges leaves `hs_out` unchanged.
- R6: With `dejit_n` low for the whole interval, `hs_out` changes only PIPE_LAT-1 edges after a phase-0 edge. The new value equals the `hs_in` sampled at that phase-0 edge.
- R7: A change on `dejit_n` switches `hs_out` to the other path within the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Data enable of the pixel stream; its rising edge restarts the grid |
| hs_in | input | 1 | Raw, possibly jittery HSYNC |
| dejit_n | input | 1 | Low: grid alignment on; high: fixed-latency bypass |
| hs_out | output | 1 | Aligned or delayed HSYNC |

## Verification
The bench builds the block with GRID=8 and PIPE_LAT=2. This gives every possible alignment delay, from 0 through 7 clocks. An edge placed at each of the eight phases lands either on the same grid point or a full group later. It also gives a two-register pipe, in which the off-by-one errors between the bypass and the aligned path show up. Re-triggering DE in mid-group moves the grid. The bench checks that the commit point follows the new phase and not the old one.

// File: rtl/hsync_aligner.sv
module hsync_aligner #(
  parameter int GRID     = 8,
  parameter int PIPE_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  input  logic hs_in,
  input  logic dejit_n,
  output logic hs_out
);
  localparam int CW = (GRID > 1) ? $clog2(GRID) : 1;
  localparam logic [CW-1:0] LAST = CW'(GRID - 1);

  logic          de_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ph_now;
  logic          at_grid;
  logic          held;
  logic          byp_out;
  logic          aln_out;

  assign ph_now  = (de_in && !de_q) ? '0 : cnt;
  assign at_grid = (ph_now == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      de_q <= de_in;
      cnt  <= (ph_now == LAST) ? '0 : ph_now + 1'b1;
      if (at_grid) held <= hs_in;
    end
  end

  generate
    if (PIPE_LAT == 1) begin : g_lat1
      logic byp_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= hs_in;
      assign byp_out = byp_q;
      assign aln_out = held;
    end else begin : g_latn
      logic [PIPE_LAT-1:0] byp_sr;
      logic [PIPE_LAT-2:0] aln_sr;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          byp_sr <= '0;
          aln_sr <= '0;
        end else begin
          byp_sr <= {byp_sr[PIPE_LAT-2:0], hs_in};
          if (PIPE_LAT == 2) aln_sr <= held;
          else               aln_sr <= {aln_sr[PIPE_LAT-3:0], held};
        end
      assign byp_out = byp_sr[PIPE_LAT-1];
      assign aln_out = aln_sr[PIPE_LAT-2];
    end
  endgenerate

  assign hs_out = dejit_n ? byp_out : aln_out;
endmodule

// File: rtl/hsync_aligner_chk.sv
module hsync_aligner_chk #(
  parameter int GRID     = 8,
  parameter int PIPE_LAT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic de_in,
  input logic hs_in,
  input logic dejit_n,
  input logic hs_out
);
  localparam int CW = (GRID > 1) ? $clog2(GRID) : 1;

  logic [PIPE_LAT-1:0] hv;
  logic [PIPE_LAT-1:0] bv;
  logic [CW-1:0]       pc;
  logic                dp;
  logic                bnd;

  assign bnd = (de_in && !dp) || (pc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv <= '0;
      bv <= '0;
      pc <= '0;
      dp <= 1'b0;
    end else begin
      dp <= de_in;
      if (de_in && !dp) pc <= (GRID > 1) ? CW'(1) : '0;
      else              pc <= (int'(pc) == GRID - 1) ? '0 : pc + 1'b1;
      for (int i = PIPE_LAT - 1; i > 0; i--) begin
        hv[i] <= hv[i-1];
        bv[i] <= bv[i-1];
      end
      hv[0] <= hs_in;
      bv[0] <= bnd;
    end
  end

  always @(posedge clk)
    if (!rst_n) p_reset_low_r1: assert (hs_out == 1'b0);

  p_bypass_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dejit_n |-> hs_out == hv[PIPE_LAT-1]);

  p_commit_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dejit_n && !$past(dejit_n) && hs_out != $past(hs_out)) |-> hs_out == hv[PIPE_LAT-1]);

  p_grid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dejit_n && !$past(dejit_n) && hs_out != $past(hs_out)) |-> bv[PIPE_LAT-1]);
endmodule

bind hsync_aligner hsync_aligner_chk #(.GRID(GRID), .PIPE_LAT(PIPE_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .de_in(de_in), .hs_in(hs_in),
  .dejit_n(dejit_n), .hs_out(hs_out)
);

// File: tb/tb_hsync_aligner.sv
module tb_hsync_aligner;
  localparam int G = 8;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de = 1'b0;
  logic hs = 1'b0;
  logic dejit_n = 1'b1;
  logic hs_out;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  hsync_aligner #(.GRID(G), .PIPE_LAT(L)) dut (
    .clk(clk), .rst_n(rst_n), .de_in(de), .hs_in(hs),
    .dejit_n(dejit_n), .hs_out(hs_out)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  task automatic tick(input logic d, input logic h);
    de = d;
    hs = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(input logic h);
    for (int i = 0; i < 12; i++) tick(1'b0, h);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; dejit_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    chk(hs_out, 1'b0, "R1", "during reset");
    hs = 1'b0;
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    chk(hs_out, 1'b0, "R1", "first cycle after release");
  endtask

  task automatic t_bypass;
    logic [23:0] pat = 24'b1011_0011_1000_1101_0100_1110;
    dejit_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      tick(i[0], pat[i]);
      if (i >= L - 1) chk(hs_out, pat[i-L+1], "R2", $sformatf("bypass step %0d", i));
    end
  endtask

  task automatic t_edge(input int k, input logic pol);
    int b = (k == 0) ? 0 : G;
    dejit_n = 1'b0;
    settle(!pol);
    for (int i = 0; i <= b + L - 1; i++) begin
      tick(1'b1, (i >= k) ? pol : !pol);
      if (i == b + L - 2) chk(hs_out, !pol, "R4", $sformatf("before commit k=%0d", k));
      if (i == b + L - 1) chk(hs_out, pol, "R4", $sformatf("at commit k=%0d", k));
    end
  endtask

  task automatic t_glitch;
    int errs = 0;
    dejit_n = 1'b0;
    settle(1'b0);
    for (int i = 0; i < 14; i++) begin
      tick(1'b1, (i >= 2 && i <= 6) ? 1'b1 : 1'b0);
      if (hs_out !== 1'b0) errs++;
    end
    chk(errs == 0, 1'b1, "R5", "short pulse between grid points");
  endtask

  task automatic t_realign;
    dejit_n = 1'b0;
    settle(1'b0);
    for (int i = 0; i <= 14; i++) begin
      tick((i == 4) ? 1'b0 : 1'b1, (i >= 6) ? 1'b1 : 1'b0);
      if (i == 9)  chk(hs_out, 1'b0, "R3", "old grid point ignored");
      if (i == 13) chk(hs_out, 1'b0, "R3", "before new grid point");
      if (i == 14) chk(hs_out, 1'b1, "R3", "new grid point commit");
    end
  endtask

  task automatic t_switch;
    dejit_n = 1'b0;
    settle(1'b0);
    for (int i = 0; i <= 3; i++) tick(1'b1, (i >= 1) ? 1'b1 : 1'b0);
    chk(hs_out, 1'b0, "R6", "aligned path still low mid-group");
    dejit_n = 1'b1;
    #1;
    chk(hs_out, 1'b1, "R7", "bypass selected same cycle");
    dejit_n = 1'b0;
    #1;
    chk(hs_out, 1'b0, "R7", "aligned selected same cycle");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bypass();
    for (int k = 0; k < G; k++) t_edge(k, 1'b1);
    t_edge(5, 1'b0);
    t_glitch();
    t_realign();
    t_switch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule